// File: doc/BRIEF.md
# Page-Mapped Chip-Select Sequencer with Bus Clock

This block drives the bus clock of an 8-bit processor and turns its upper address byte into a set of chip selects. A fast input clock is split into bus cycles of 16 sub-cycles each. The processor clock output, `phi0`, is low in the first half of every bus cycle and high in the second half. During the low half, the block samples the page number (address bits 15..8). It looks the page up in a 256-entry rewritable table. It registers the stored pattern onto the active-low chip-select outputs three sub-cycles before `phi0` rises.

A host rewrites the table through a simple write port while it holds a load-enable input high. This lets one board take on a different memory layout without any wiring change, for example with I/O placed in page zero. The block also holds the processor in reset for a bounded number of bus cycles after power-up or after a reset request. It offers a single-step mode in which the processor runs one bus cycle per step pulse.

Top module: `pagemap_busclk`

## Requirements
- R1: A sub-cycle counter runs 0..15 and wraps. `phi0` is 0 while the counter is 0..7 and 1 while it is 8..15. Asynchronous reset puts the counter at 0, and each running clock edge advances it by one.
- R2: `addr_hi` is captured on the running edge that moves the counter from 3 to 4. That captured page is the table index for the following lookup.
- R3: `cs_n` takes its new value only on the running edge that moves the counter from 4 to 5, which is three sub-cycles before `phi0` rises. It holds that value until the next such edge.
- R4: After asynchronous reset `cs_n` is 8'hFF. It stays 8'hFF at every update until a load session has finished, meaning `load_en` has gone from 1 to 0 once.
- R5: A table entry is written (`map_wdata` at index `map_idx`) only on an edge where both `map_we` and `load_en` are 1. A write strobe while `load_en` is 0 leaves the entry unchanged.
- R6: On every edge where `load_en` is 1, `cs_n` is set to 8'hFF.
- R7: While `step_mode` is 1 and the processor is out of reset, the counter stops at 0 (`phi0` low) after finishing a cycle. Each rising edge of `step_pulse` lets exactly one more full bus cycle run, and one such request can be queued while a cycle is running. Step pulses seen while `step_mode` is 0 are discarded.
- R8: `cpu_rst_n` is 0 after asynchronous reset. It rises on the 17th cycle-end edge (counter 15 to 0) after the reset request ends, which is the 272nd edge after asynchronous reset is released. At that moment `phi0` is low.
- R9: An edge with `rst_req` at 1 drives `cpu_rst_n` to 0 and restarts the R8 count.
- R10: While `cpu_rst_n` is 0, the counter advances on every edge even if `step_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-cycle clock, 16 periods per bus cycle |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous processor reset request, active high |
| step_mode | input | 1 | 1 selects single-step operation |
| step_pulse | input | 1 | Step request; a rising edge runs one bus cycle |
| addr_hi | input | 8 | Processor address bits 15..8 (page number) |
| load_en | input | 1 | Table load window; chip selects idle while 1 |
| map_we | input | 1 | Table write strobe |
| map_idx | input | 8 | Table entry index for a write |
| map_wdata | input | 8 | Chip-select pattern to store |
| phi0 | output | 1 | Processor bus clock |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cs_n | output | 8 | Active-low chip selects from the table |

## Verification
The page lookup is tested with a fixed page held across many cycles, which shows whether the right entry is returned, including an entry that was hit by a write strobe outside the load window. It is also tested with a new random page on every sub-cycle, which shows whether the page is captured at the one sampling slot rather than earlier or later. Random load bursts, reset requests, mode changes and step pulses are mixed into the random traffic. This tells apart faults in update timing, in idling during loads, and in step bookkeeping. The first reset is taken with single-step mode already on, which separates a divider that keeps running during reset from one that stalls.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;
    // Default geometry of the bus cycle and the page table.
    localparam int unsigned SUBS_DEF     = 16;  // sub-cycles per bus cycle
    localparam int unsigned CS_LEAD_DEF  = 3;   // sub-cycles of chip-select lead before phi0 rises
    localparam int unsigned PAGE_W_DEF   = 8;   // page number width
    localparam int unsigned SEL_W_DEF    = 8;   // chip-select lines
    localparam int unsigned HOLD_CYC_DEF = 16;  // full bus cycles of processor reset

    // Sub-cycle counter successor with wrap.
    function automatic int unsigned next_sub(input int unsigned cur, input int unsigned subs);
        return (cur == subs - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/pm_phase.sv
module pm_phase #(
    parameter int unsigned SUBS  = 16,
    parameter int unsigned SUB_W = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             step_mode,
    input  logic             step_pulse,
    input  logic             rst_active,
    output logic [SUB_W-1:0] sub,
    output logic             adv,
    output logic             wrap,
    output logic             phi0
);
    import pagemap_pkg::*;

    localparam logic [SUB_W-1:0] LAST = SUB_W'(SUBS - 1);
    localparam logic [SUB_W-1:0] HALF = SUB_W'(SUBS / 2);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             cred;   // one queued step request
        logic             prev;   // step_pulse of the previous edge
        logic             phi;
    } ph_t;

    ph_t ph_q, ph_d;
    logic run_c, take_c, rise_c;

    always_comb begin
        ph_d    = ph_q;
        rise_c  = step_pulse & ~ph_q.prev;
        run_c   = ~step_mode | rst_active | (ph_q.sub != '0) | ph_q.cred;
        take_c  = step_mode & ~rst_active & (ph_q.sub == '0) & ph_q.cred;
        ph_d.prev = step_pulse;
        if (run_c) begin
            ph_d.sub = SUB_W'(next_sub(int'(ph_q.sub), SUBS));
        end
        ph_d.cred = step_mode & ((ph_q.cred & ~take_c) | rise_c);
        ph_d.phi  = (ph_d.sub >= HALF);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign sub  = ph_q.sub;
    assign adv  = run_c;
    assign wrap = run_c & (ph_q.sub == LAST);
    assign phi0 = ph_q.phi;
endmodule

// File: rtl/pm_rstgen.sv
module pm_rstgen #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_req,
    input  logic wrap,
    output logic rst_active
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } rg_t;

    rg_t rg_q, rg_d;

    always_comb begin
        rg_d = rg_q;
        if (rst_req) begin
            rg_d.act = 1'b1;
            rg_d.cnt = '0;
        end else if (rg_q.act && wrap) begin
            // The first boundary may close a partial cycle, so release waits one extra.
            if (rg_q.cnt == CNT_END) begin
                rg_d.act = 1'b0;
            end else begin
                rg_d.cnt = rg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rg_q.act <= 1'b1;
            rg_q.cnt <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign rst_active = rg_q.act;
endmodule

// File: rtl/pm_table.sv
module pm_table #(
    parameter int unsigned PAGE_W    = 8,
    parameter int unsigned SEL_W     = 8,
    parameter int unsigned SUB_W     = 4,
    parameter int unsigned ADDR_SLOT = 4,
    parameter int unsigned CS_SLOT   = 5
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [SUB_W-1:0]  sub,
    input  logic              adv,
    input  logic [PAGE_W-1:0] addr_hi,
    input  logic              load_en,
    input  logic              map_we,
    input  logic [PAGE_W-1:0] map_idx,
    input  logic [SEL_W-1:0]  map_wdata,
    output logic [SEL_W-1:0]  cs_n
);
    localparam int unsigned DEPTH = 1 << PAGE_W;
    localparam logic [SUB_W-1:0] GRAB_AT = SUB_W'(ADDR_SLOT - 1);
    localparam logic [SUB_W-1:0] DRIVE_AT = SUB_W'(CS_SLOT - 1);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SEL_W-1:0]  cs;
        logic              ok;      // a load session has completed
        logic              ld_prev;
    } tb_t;

    tb_t tb_q, tb_d;
    logic [SEL_W-1:0] store [DEPTH];
    logic [SEL_W-1:0] rd_c;

    // Table storage carries no reset; entries are meaningful only once ok is set.
    always_ff @(posedge clk) begin
        if (load_en && map_we) begin
            store[map_idx] <= map_wdata;
        end
    end

    assign rd_c = store[tb_q.page];

    always_comb begin
        tb_d = tb_q;
        tb_d.ld_prev = load_en;
        if (tb_q.ld_prev && !load_en) begin
            tb_d.ok = 1'b1;
        end
        if (adv && sub == GRAB_AT) begin
            tb_d.page = addr_hi;
        end
        if (load_en) begin
            tb_d.cs = '1;
        end else if (adv && sub == DRIVE_AT) begin
            tb_d.cs = tb_q.ok ? rd_c : '1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            tb_q.page    <= '0;
            tb_q.cs      <= '1;
            tb_q.ok      <= 1'b0;
            tb_q.ld_prev <= 1'b0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign cs_n = tb_q.cs;
endmodule

// File: rtl/pagemap_busclk.sv
module pagemap_busclk
    import pagemap_pkg::*;
#(
    parameter int unsigned SUBS     = SUBS_DEF,
    parameter int unsigned CS_LEAD  = CS_LEAD_DEF,
    parameter int unsigned PAGE_W   = PAGE_W_DEF,
    parameter int unsigned SEL_W    = SEL_W_DEF,
    parameter int unsigned HOLD_CYC = HOLD_CYC_DEF
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rst_req,
    input  logic              step_mode,
    input  logic              step_pulse,
    input  logic [PAGE_W-1:0] addr_hi,
    input  logic              load_en,
    input  logic              map_we,
    input  logic [PAGE_W-1:0] map_idx,
    input  logic [SEL_W-1:0]  map_wdata,
    output logic              phi0,
    output logic              cpu_rst_n,
    output logic [SEL_W-1:0]  cs_n
);
    localparam int unsigned SUB_W     = $clog2(SUBS);
    localparam int unsigned HALF      = SUBS / 2;
    localparam int unsigned CS_SLOT   = HALF - CS_LEAD;
    localparam int unsigned ADDR_SLOT = CS_SLOT - 1;

    generate
        if (CS_LEAD < 1 || CS_LEAD + 2 > HALF) begin : g_bad_lead
            $error("chip-select lead leaves no room for page capture");
        end
    endgenerate

    logic [SUB_W-1:0] sub;
    logic             adv;
    logic             wrap;
    logic             rst_active;

    pm_phase #(.SUBS(SUBS), .SUB_W(SUB_W)) u_phase (
        .clk        (clk),
        .arst_n     (arst_n),
        .step_mode  (step_mode),
        .step_pulse (step_pulse),
        .rst_active (rst_active),
        .sub        (sub),
        .adv        (adv),
        .wrap       (wrap),
        .phi0       (phi0)
    );

    pm_rstgen #(.HOLD_CYC(HOLD_CYC)) u_rst (
        .clk        (clk),
        .arst_n     (arst_n),
        .rst_req    (rst_req),
        .wrap       (wrap),
        .rst_active (rst_active)
    );

    pm_table #(
        .PAGE_W   (PAGE_W),
        .SEL_W    (SEL_W),
        .SUB_W    (SUB_W),
        .ADDR_SLOT(ADDR_SLOT),
        .CS_SLOT  (CS_SLOT)
    ) u_table (
        .clk       (clk),
        .arst_n    (arst_n),
        .sub       (sub),
        .adv       (adv),
        .addr_hi   (addr_hi),
        .load_en   (load_en),
        .map_we    (map_we),
        .map_idx   (map_idx),
        .map_wdata (map_wdata),
        .cs_n      (cs_n)
    );

    assign cpu_rst_n = ~rst_active;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int unsigned SUB_W   = 4,
    parameter int unsigned SEL_W   = 8,
    parameter int unsigned HALF    = 8,
    parameter int unsigned CS_SLOT = 5
) (
    input logic             clk,
    input logic             arst_n,
    input logic             rst_req,
    input logic             step_mode,
    input logic             load_en,
    input logic [SUB_W-1:0] sub,
    input logic             phi0,
    input logic             cpu_rst_n,
    input logic [SEL_W-1:0] cs_n
);
    // R1: phi0 edges sit on the half-cycle and cycle boundaries
    a_r1_phi_rise: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(phi0) |-> sub == SUB_W'(HALF));
    a_r1_phi_fall: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(phi0) |-> sub == '0);

    // R3: outside loading, chip selects change only into the drive slot
    a_r3_cs_slot: assert property (@(posedge clk) disable iff (!arst_n)
        (!$stable(cs_n) && !$past(load_en)) |-> sub == SUB_W'(CS_SLOT));

    // R3: chip selects are settled across the lead before phi0 rises
    a_r3_cs_lead: assert property (@(posedge clk) disable iff (!arst_n)
        ($rose(phi0) && !load_en && !$past(load_en) && !$past(load_en, 2))
        |-> ($stable(cs_n) && $past($stable(cs_n))));

    // R6: loading idles every chip select
    a_r6_load_idle: assert property (@(posedge clk) disable iff (!arst_n)
        load_en |=> cs_n == '1);

    // R7: a stalled divider sits at sub-cycle 0 with phi0 low
    a_r7_halt_low: assert property (@(posedge clk) disable iff (!arst_n)
        (step_mode && cpu_rst_n && $stable(sub)) |-> (sub == '0 && !phi0));

    // R8: processor reset ends in the low phase at a cycle start
    a_r8_release_low: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(cpu_rst_n) |-> (!phi0 && sub == '0));

    // R9: a reset request takes effect on the next edge
    a_r9_req: assert property (@(posedge clk) disable iff (!arst_n)
        rst_req |=> !cpu_rst_n);

    // R10: the divider never stalls while the processor is in reset
    a_r10_run_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
        !cpu_rst_n |=> !$stable(sub));
endmodule

bind pagemap_busclk pm_checker #(
    .SUB_W  (SUB_W),
    .SEL_W  (SEL_W),
    .HALF   (HALF),
    .CS_SLOT(CS_SLOT)
) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_req   (rst_req),
    .step_mode (step_mode),
    .load_en   (load_en),
    .sub       (sub),
    .phi0      (phi0),
    .cpu_rst_n (cpu_rst_n),
    .cs_n      (cs_n)
);

// File: tb/sim_pagemap_busclk.sv
module sim_pagemap_busclk;
    logic       clk = 1'b0;
    logic       arst_n, rst_req, step_mode, step_pulse, load_en, map_we;
    logic [7:0] addr_hi, map_idx, map_wdata;
    logic       phi0, cpu_rst_n;
    logic [7:0] cs_n;

    always #4 clk = ~clk;  // 125 MHz

    pagemap_busclk u0 (
        .clk(clk), .arst_n(arst_n), .rst_req(rst_req), .step_mode(step_mode),
        .step_pulse(step_pulse), .addr_hi(addr_hi), .load_en(load_en),
        .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
        .phi0(phi0), .cpu_rst_n(cpu_rst_n), .cs_n(cs_n)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  cmp_on = 0;
    bit  done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Expected-value model built from the requirements.
    int         m_sub, m_rcnt;
    bit         m_cred, m_prev, m_rst, m_ok, m_ldp;
    logic [7:0] m_page, m_cs;
    logic [7:0] m_map [256];

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            m_sub = 0; m_cred = 0; m_prev = 0; m_rst = 1; m_rcnt = 0;
            m_page = 8'h00; m_cs = 8'hFF; m_ok = 0; m_ldp = 0;
        end else begin : model_step
            bit         rise, run, take, wrapc;
            logic [7:0] look;
            rise  = step_pulse && !m_prev;
            run   = !step_mode || m_rst || m_sub != 0 || m_cred;
            take  = step_mode && !m_rst && m_sub == 0 && m_cred;
            wrapc = run && m_sub == 15;
            look  = m_ok ? m_map[m_page] : 8'hFF;
            if (load_en) m_cs = 8'hFF;                 // R6
            else if (run && m_sub == 4) m_cs = look;   // R3, R4
            if (run && m_sub == 3) m_page = addr_hi;   // R2
            if (m_ldp && !load_en) m_ok = 1;
            m_ldp = load_en;
            if (load_en && map_we) m_map[map_idx] = map_wdata;  // R5
            if (rst_req) begin m_rst = 1; m_rcnt = 0; end       // R9
            else if (m_rst && wrapc) begin                      // R8
                if (m_rcnt == 16) m_rst = 0; else m_rcnt++;
            end
            m_cred = step_mode && ((m_cred && !take) || rise); // R7
            m_prev = step_pulse;
            if (run) m_sub = (m_sub == 15) ? 0 : m_sub + 1;    // R1, R10
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (arst_n && cmp_on) begin
            chk("R1 R7 phi0", {31'd0, phi0}, {31'd0, (m_sub >= 8)});
            chk("R3 cs_n", {24'd0, cs_n}, {24'd0, m_cs});
            chk("R8 cpu_rst_n", {31'd0, cpu_rst_n}, {31'd0, !m_rst});
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        int unsigned sd;
        int          k, highs;
        logic [7:0]  keep20;
        sd = $urandom(32'd4127);
        arst_n = 0; rst_req = 0; step_mode = 1; step_pulse = 0;
        addr_hi = 0; load_en = 0; map_we = 0; map_idx = 0; map_wdata = 0;
        repeat (3) @(negedge clk);
        chk("R4 cs_n in reset", {24'd0, cs_n}, 32'hFF);
        chk("R8 cpu_rst_n in reset", {31'd0, cpu_rst_n}, 32'd0);
        chk("R1 phi0 in reset", {31'd0, phi0}, 32'd0);
        arst_n = 1; cmp_on = 1;

        // R10 + R8: step mode on through reset, release on edge 272
        k = 0;
        while (!cpu_rst_n && k < 1000) begin @(negedge clk); k++; end
        chk("R8 R10 release edge", k, 272);
        chk("R8 phi0 low at release", {31'd0, phi0}, 32'd0);

        // R7: halted until a step
        highs = 0;
        repeat (40) begin @(negedge clk); if (phi0) highs++; end
        chk("R7 halted", highs, 0);
        chk("R4 no map yet", {24'd0, cs_n}, 32'hFF);
        step_pulse = 1; @(negedge clk); step_pulse = 0;
        highs = 0;
        repeat (40) begin @(negedge clk); if (phi0) highs++; end
        chk("R7 one step", highs, 8);

        // R6, R5: load the table
        step_mode = 0;
        @(negedge clk);
        load_en = 1; keep20 = 8'h00;
        for (int i = 0; i < 256; i++) begin
            map_we = 1; map_idx = 8'(i); map_wdata = 8'($urandom);
            if (i == 8'h20) keep20 = map_wdata;
            @(negedge clk);
            if (i == 100) chk("R6 idle while loading", {24'd0, cs_n}, 32'hFF);
        end
        map_we = 0; load_en = 0;
        @(negedge clk);
        map_we = 1; map_idx = 8'h20; map_wdata = ~keep20;  // outside load window
        @(negedge clk);
        map_we = 0; addr_hi = 8'h20;
        repeat (40) @(negedge clk);
        chk("R5 R2 held page", {24'd0, cs_n}, {24'd0, keep20});

        // R9: request resets processor on next edge
        rst_req = 1; @(negedge clk); rst_req = 0;
        chk("R9 request", {31'd0, cpu_rst_n}, 32'd0);
        k = 0;
        while (!cpu_rst_n && k < 1000) begin @(negedge clk); k++; end
        chk("R8 back out of reset", {31'd0, cpu_rst_n}, 32'd1);

        // Random traffic mixed with loads, steps, mode flips and resets
        for (int c = 0; c < 6000; c++) begin
            int unsigned r;
            r = $urandom_range(0, 999);
            addr_hi = 8'($urandom);
            step_pulse = ($urandom_range(0, 9) == 0);
            if (r < 10) step_mode = ~step_mode;
            rst_req = (r >= 10 && r < 13);
            if (r >= 20 && r < 25) load_en = 1;
            else if (load_en && r > 800) load_en = 0;
            map_we = ($urandom_range(0, 1) == 1);
            map_idx = 8'($urandom);
            map_wdata = 8'($urandom);
            @(negedge clk);
        end
        load_en = 0; map_we = 0; rst_req = 0; step_mode = 0;
        repeat (40) @(negedge clk);
        chk("R3 settled after traffic", {24'd0, cs_n}, {24'd0, m_cs});
        wrap_up();
    end
endmodule